// File: doc/BRIEF.md
# CPU Special I/O Register Bank

This block holds the processor's special registers that occupy the upper eight ports of its 64-port I/O space. They are four data-address page registers (D, X, Y, Z), an extension register for indirect jumps, a stack pointer split into a low byte and a high byte, and the status byte. The page and jump-extension registers are exposed as 24-bit values whose upper byte holds the programmed page. The datapath can therefore join them with a 16-bit pointer without any further shifting.

Accesses arrive on a valid/ready request channel that carries a write flag, a 6-bit port number and write data. A request is transferred on a cycle where both `req_valid` and `req_ready` are high. The requester must keep its fields stable while valid is high and ready is low.

Ports 0x38 to 0x3F are served locally. Any other port is passed straight to an external I/O request channel, and the address on that channel is the I/O base plus the port number. Read data comes back on one response slot with valid/ready. That slot holds its data until `rsp_ready` is seen. At most one external read may be outstanding. While it is open, the block accepts no new request.

Feature parameters decide which page registers can be written and whether the stack pointer high byte can be written.

Top module: `sio_regbank`

## Requirements
- R1: A write to port 0x38, 0x39, 0x3A or 0x3B (page D, X, Y, Z in that order) or to port 0x3C (jump extension) stores the byte in bits 23:16 of that register's 24-bit output, with bits 15:0 zero. A read of the same port returns that byte.
- R2: Bit k of `HAS_PAGE` enables writes to port 0x38+k. A write to a disabled page port leaves the register unchanged, and a read of it returns the stored value, which is zero from reset.
- R3: The jump extension register at port 0x3C is always writable.
- R4: A write to port 0x3D replaces stack pointer bits 7:0 and keeps bits 15:8. A read returns bits 7:0.
- R5: A write to port 0x3E replaces stack pointer bits 15:8 when `SP_WIDE` is 1 and is ignored when it is 0. A read returns bits 15:8.
- R6: Port 0x3F reads and writes the status byte.
- R7: A request to a port below 0x38 is forwarded on the external channel with address `IO_BASE` + port and with the write flag and data unchanged. It is accepted exactly when the external channel is ready.
- R8: An accepted external read is answered with the external response data on the response slot. Until that response arrives, `req_ready` stays low and the read stays pending.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response valid and data hold steady.
- R10: After reset, all page registers, the jump extension and the status byte are zero, and the stack pointer equals `SP_RESET`.
- R11: An accepted local read gives `rsp_valid` with the register value on the next cycle. Local writes are accepted regardless of the response slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 6 | I/O port number |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data |
| ext_req_valid | output | 1 | Forwarded request valid |
| ext_req_ready | input | 1 | External bus takes request |
| ext_write | output | 1 | Forwarded write flag |
| ext_addr | output | EXT_AW | IO_BASE + port |
| ext_wdata | output | 8 | Forwarded write byte |
| ext_rsp_valid | input | 1 | External read data valid |
| ext_rsp_ready | output | 1 | Block takes external read data |
| ext_rsp_data | input | 8 | External read data |
| page_d | output | 24 | Page D, byte in bits 23:16 |
| page_x | output | 24 | Page X |
| page_y | output | 24 | Page Y |
| page_z | output | 24 | Page Z |
| jump_ext | output | 24 | Indirect jump extension |
| sp | output | 16 | Stack pointer |
| sreg | output | 8 | Status byte |

## Verification
The hardest case to reach is an external read that is pending while the response slot is still full, because `rsp_ready` is being held low. In that state the external response must wait, and new requests, local ones included, must stay blocked. The stimulus reaches it with a long random phase that toggles request valid, `rsp_ready`, `ext_req_ready` and `ext_rsp_valid` on their own. Two instances run side by side, one with a narrow stack pointer and the complementary page-enable mask, so that every gated write is seen both taking effect and being ignored.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int PORT_W = 6;
  localparam int NPAGE  = 4;
  localparam logic [PORT_W-1:0] PORT_PAGE0 = 6'h38;
  localparam logic [PORT_W-1:0] PORT_JEXT  = 6'h3C;
  localparam logic [PORT_W-1:0] PORT_SPL   = 6'h3D;
  localparam logic [PORT_W-1:0] PORT_SPH   = 6'h3E;
  localparam logic [PORT_W-1:0] PORT_STAT  = 6'h3F;

  function automatic logic is_local(input logic [PORT_W-1:0] p);
    return p[5:3] == 3'b111;
  endfunction
endpackage

// File: rtl/sio_page_reg.sv
module sio_page_reg #(
  parameter bit WRITABLE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  wdata,
  output logic [23:0] val
);
  logic [7:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                page_q <= '0;
    else if (we && WRITABLE)   page_q <= wdata;
  end

  assign val = {page_q, 16'h0000};

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && WRITABLE) |=> val[23:16] == $past(wdata));
  p_locked_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITABLE |=> $stable(val));
endmodule

// File: rtl/sio_stack_ptr.sv
module sio_stack_ptr #(
  parameter bit          WIDE  = 1'b1,
  parameter logic [15:0] RESET = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_lo,
  input  logic        we_hi,
  input  logic [7:0]  wdata,
  output logic [15:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n) sp <= RESET;
    else begin
      if (we_lo)         sp[7:0]  <= wdata;
      if (we_hi && WIDE) sp[15:8] <= wdata;
    end
  end

  p_lo_keeps_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && !we_hi) |=> sp[15:8] == $past(sp[15:8]));
  p_narrow_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !WIDE |=> $stable(sp[15:8]));
endmodule

// File: rtl/sio_rsp_slot.sv
module sio_rsp_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_own,
  input  logic [7:0] own_data,
  input  logic       ext_take,
  input  logic       ext_rsp_valid,
  input  logic [7:0] ext_rsp_data,
  output logic       ext_rsp_ready,
  input  logic       rsp_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rd_pend,
  output logic       slot_free
);
  logic ext_hs;

  assign slot_free     = !rsp_valid || rsp_ready;
  assign ext_rsp_ready = rd_pend && slot_free;
  assign ext_hs        = ext_rsp_valid && ext_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rd_pend   <= 1'b0;
    end else begin
      if (load_own) begin
        rsp_valid <= 1'b1;
        rsp_data  <= own_data;
      end else if (ext_hs) begin
        rsp_valid <= 1'b1;
        rsp_data  <= ext_rsp_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (ext_take)    rd_pend <= 1'b1;
      else if (ext_hs) rd_pend <= 1'b0;
    end
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
  p_pend_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !ext_rsp_valid) |=> rd_pend);
  p_ext_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hs |=> rsp_valid && rsp_data == $past(ext_rsp_data));
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter logic [NPAGE-1:0] HAS_PAGE = 4'b1111,
  parameter bit               SP_WIDE  = 1'b1,
  parameter logic [15:0]      SP_RESET = 16'h0000,
  parameter int               EXT_AW   = 16,
  parameter logic [EXT_AW-1:0] IO_BASE = 16'h0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [5:0]        req_port,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              ext_req_valid,
  input  logic              ext_req_ready,
  output logic              ext_write,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [7:0]        ext_wdata,
  input  logic              ext_rsp_valid,
  output logic              ext_rsp_ready,
  input  logic [7:0]        ext_rsp_data,
  output logic [23:0]       page_d,
  output logic [23:0]       page_x,
  output logic [23:0]       page_y,
  output logic [23:0]       page_z,
  output logic [23:0]       jump_ext,
  output logic [15:0]       sp,
  output logic [7:0]        sreg
);
  logic        local_hit, accept, wr_acc, rd_local, ext_take;
  logic        rd_pend, slot_free;
  logic [7:0]  rd_byte;
  logic [23:0] pg [NPAGE];
  logic [7:0]  stat_q;

  assign local_hit = is_local(req_port);
  assign req_ready = rd_pend ? 1'b0
                   : local_hit ? (req_write || slot_free)
                   : ext_req_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && local_hit && req_write;
  assign rd_local  = accept && local_hit && !req_write;
  assign ext_take  = accept && !local_hit && !req_write;

  assign ext_req_valid = req_valid && !local_hit && !rd_pend;
  assign ext_write     = req_write;
  assign ext_wdata     = req_wdata;
  assign ext_addr      = IO_BASE + EXT_AW'(req_port);

  for (genvar k = 0; k < NPAGE; k++) begin : g_page
    sio_page_reg #(.WRITABLE(HAS_PAGE[k])) u_page (
      .clk(clk), .rst_n(rst_n),
      .we(wr_acc && req_port == PORT_PAGE0 + 6'(k)),
      .wdata(req_wdata), .val(pg[k]));
  end

  assign page_d = pg[0];
  assign page_x = pg[1];
  assign page_y = pg[2];
  assign page_z = pg[3];

  sio_page_reg #(.WRITABLE(1'b1)) u_jext (
    .clk(clk), .rst_n(rst_n),
    .we(wr_acc && req_port == PORT_JEXT),
    .wdata(req_wdata), .val(jump_ext));

  sio_stack_ptr #(.WIDE(SP_WIDE), .RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .we_lo(wr_acc && req_port == PORT_SPL),
    .we_hi(wr_acc && req_port == PORT_SPH),
    .wdata(req_wdata), .sp(sp));

  always_ff @(posedge clk) begin
    if (!rst_n)                              stat_q <= '0;
    else if (wr_acc && req_port == PORT_STAT) stat_q <= req_wdata;
  end
  assign sreg = stat_q;

  always_comb begin
    unique case (req_port[2:0])
      3'd0:    rd_byte = pg[0][23:16];
      3'd1:    rd_byte = pg[1][23:16];
      3'd2:    rd_byte = pg[2][23:16];
      3'd3:    rd_byte = pg[3][23:16];
      3'd4:    rd_byte = jump_ext[23:16];
      3'd5:    rd_byte = sp[7:0];
      3'd6:    rd_byte = sp[15:8];
      default: rd_byte = stat_q;
    endcase
  end

  sio_rsp_slot u_rsp (
    .clk(clk), .rst_n(rst_n),
    .load_own(rd_local), .own_data(rd_byte),
    .ext_take(ext_take),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data),
    .ext_rsp_ready(ext_rsp_ready),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rd_pend(rd_pend), .slot_free(slot_free));

  p_owned_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_local |=> rsp_valid);
  p_stat_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_port == PORT_STAT) |=> sreg == $past(req_wdata));
  p_jext_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_port == PORT_JEXT) |=> jump_ext[23:16] == $past(req_wdata));
  p_ext_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && local_hit) |-> !ext_req_valid);
endmodule

// File: tb/sio_regbank_test.sv
`timescale 1ns/100ps
module sio_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid = 0, req_write = 0, rsp_ready = 0;
  logic       ext_req_ready = 0, ext_rsp_valid = 0;
  logic [5:0] req_port = 0;
  logic [7:0] req_wdata = 0, ext_rsp_data = 0;

  logic        o_rr [2], o_rv [2], o_ev [2], o_ew [2], o_er [2];
  logic [7:0]  o_rd [2], o_ed [2], o_sr [2];
  logic [15:0] o_ea [2], o_sp [2];
  logic [23:0] o_pd [2], o_px [2], o_py [2], o_pz [2], o_je [2];

  sio_regbank #(.HAS_PAGE(4'b0101), .SP_WIDE(1'b1), .SP_RESET(16'h08FF)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(o_rr[0]),
    .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(o_rv[0]), .rsp_ready(rsp_ready), .rsp_data(o_rd[0]),
    .ext_req_valid(o_ev[0]), .ext_req_ready(ext_req_ready), .ext_write(o_ew[0]),
    .ext_addr(o_ea[0]), .ext_wdata(o_ed[0]), .ext_rsp_valid(ext_rsp_valid),
    .ext_rsp_ready(o_er[0]), .ext_rsp_data(ext_rsp_data),
    .page_d(o_pd[0]), .page_x(o_px[0]), .page_y(o_py[0]), .page_z(o_pz[0]),
    .jump_ext(o_je[0]), .sp(o_sp[0]), .sreg(o_sr[0]));

  sio_regbank #(.HAS_PAGE(4'b1010), .SP_WIDE(1'b0), .SP_RESET(16'h0000)) uut_n (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(o_rr[1]),
    .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(o_rv[1]), .rsp_ready(rsp_ready), .rsp_data(o_rd[1]),
    .ext_req_valid(o_ev[1]), .ext_req_ready(ext_req_ready), .ext_write(o_ew[1]),
    .ext_addr(o_ea[1]), .ext_wdata(o_ed[1]), .ext_rsp_valid(ext_rsp_valid),
    .ext_rsp_ready(o_er[1]), .ext_rsp_data(ext_rsp_data),
    .page_d(o_pd[1]), .page_x(o_px[1]), .page_y(o_py[1]), .page_z(o_pz[1]),
    .jump_ext(o_je[1]), .sp(o_sp[1]), .sreg(o_sr[1]));

  // reference model state, one set per instance
  logic [7:0]  m_pg [2][5];
  logic [15:0] m_sp [2];
  logic [7:0]  m_sr [2], m_rd [2];
  logic        m_rv [2], m_pend [2];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic page_en(int i, int k);
    logic [3:0] mask = (i == 0) ? 4'b0101 : 4'b1010;
    return mask[k];
  endfunction

  task automatic chk(string tag, string what, int i, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h", tag, what, i, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < 5; k++) m_pg[i][k] = 8'h00;
      m_sp[i] = (i == 0) ? 16'h08FF : 16'h0000;
      m_sr[i] = 8'h00; m_rd[i] = 8'h00; m_rv[i] = 0; m_pend[i] = 0;
    end
  endtask

  function automatic logic [7:0] m_read(int i, logic [5:0] p);
    if (p <= 6'h3C) return m_pg[i][p - 6'h38];
    if (p == 6'h3D) return m_sp[i][7:0];
    if (p == 6'h3E) return m_sp[i][15:8];
    return m_sr[i];
  endfunction

  task automatic step();
    logic own, slot, rr, acc, ehs;
    #1;
    for (int i = 0; i < 2; i++) begin
      own  = (req_port >= 6'h38);
      slot = !m_rv[i] || rsp_ready;
      rr   = m_pend[i] ? 1'b0 : own ? (req_write || slot) : ext_req_ready;
      chk("R8", "req_ready", i, o_rr[i], rr);
      chk("R7", "ext_req_valid", i, o_ev[i], req_valid && !own && !m_pend[i]);
      if (req_valid && !own && !m_pend[i]) begin
        chk("R7", "ext_addr", i, o_ea[i], 16'h0020 + req_port);
        chk("R7", "ext_write", i, o_ew[i], req_write);
        chk("R7", "ext_wdata", i, o_ed[i], req_wdata);
      end
      chk("R8", "ext_rsp_ready", i, o_er[i], m_pend[i] && slot);
      chk("R9 R11", "rsp_valid", i, o_rv[i], m_rv[i]);
      if (m_rv[i]) chk("R8 R9 R11", "rsp_data", i, o_rd[i], m_rd[i]);
      chk("R1 R2", "page_d", i, o_pd[i], {m_pg[i][0], 16'h0});
      chk("R1 R2", "page_x", i, o_px[i], {m_pg[i][1], 16'h0});
      chk("R1 R2", "page_y", i, o_py[i], {m_pg[i][2], 16'h0});
      chk("R1 R2", "page_z", i, o_pz[i], {m_pg[i][3], 16'h0});
      chk("R3", "jump_ext", i, o_je[i], {m_pg[i][4], 16'h0});
      chk("R4 R5", "sp", i, o_sp[i], m_sp[i]);
      chk("R6", "sreg", i, o_sr[i], m_sr[i]);
    end
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      own  = (req_port >= 6'h38);
      slot = !m_rv[i] || rsp_ready;
      rr   = m_pend[i] ? 1'b0 : own ? (req_write || slot) : ext_req_ready;
      acc  = req_valid && rr;
      ehs  = ext_rsp_valid && m_pend[i] && slot;
      if (acc && own && !req_write) begin
        m_rv[i] = 1; m_rd[i] = m_read(i, req_port);
      end else if (ehs) begin
        m_rv[i] = 1; m_rd[i] = ext_rsp_data;
      end else if (rsp_ready) m_rv[i] = 0;
      if (acc && !own && !req_write) m_pend[i] = 1;
      else if (ehs) m_pend[i] = 0;
      if (acc && own && req_write) begin
        if (req_port <= 6'h3B) begin
          if (page_en(i, int'(req_port - 6'h38))) m_pg[i][req_port - 6'h38] = req_wdata;
        end
        else if (req_port == 6'h3C) m_pg[i][4] = req_wdata;
        else if (req_port == 6'h3D) m_sp[i][7:0] = req_wdata;
        else if (req_port == 6'h3E) begin
          if (i == 0) m_sp[i][15:8] = req_wdata;
        end
        else m_sr[i] = req_wdata;
      end
    end
    @(negedge clk);
  endtask

  task automatic put(logic v, logic w, logic [5:0] p, logic [7:0] d);
    req_valid = v; req_write = w; req_port = p; req_wdata = d;
    step();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    rsp_ready = 1;
    put(0, 0, 6'h00, 8'h00);                    // R10 reset state
    // R1 R2 R3 R4 R5 R6: write every local port
    for (int k = 0; k < 8; k++) put(1, 1, 6'h38 + 6'(k), 8'hA1 + 8'(k * 17));
    put(0, 0, 6'h00, 8'h00);
    // read back every local port, R11 next-cycle data
    for (int k = 0; k < 8; k++) put(1, 0, 6'h38 + 6'(k), 8'h00);
    put(0, 0, 6'h00, 8'h00);
    // R4 low write keeps high byte
    put(1, 1, 6'h3D, 8'h5A);
    put(1, 0, 6'h3E, 8'h00);
    // R9 back-pressure: read then hold rsp_ready low
    rsp_ready = 0;
    put(1, 0, 6'h3F, 8'h00);
    put(1, 0, 6'h38, 8'h00);                    // blocked while slot full
    put(1, 1, 6'h3F, 8'h33);                    // write still accepted
    repeat (3) put(0, 0, 6'h00, 8'h00);
    rsp_ready = 1;
    put(0, 0, 6'h00, 8'h00);
    // R7 external write, not ready then ready
    ext_req_ready = 0;
    put(1, 1, 6'h05, 8'h77);
    ext_req_ready = 1;
    put(1, 1, 6'h05, 8'h77);
    // R8 external read with late response and requests during pending
    put(1, 0, 6'h12, 8'h00);
    put(1, 1, 6'h3F, 8'h99);
    put(1, 0, 6'h20, 8'h00);
    ext_rsp_data = 8'hC4; ext_rsp_valid = 1;
    put(0, 0, 6'h00, 8'h00);
    ext_rsp_valid = 0;
    put(0, 0, 6'h00, 8'h00);
    // random phase covering pending read with a full slot
    for (int n = 0; n < 3000; n++) begin
      rsp_ready     = ($urandom % 3) != 0;
      ext_req_ready = ($urandom % 2) != 0;
      ext_rsp_valid = ($urandom % 4) == 0;
      ext_rsp_data  = 8'($urandom);
      put(($urandom % 4) != 0, ($urandom % 2) != 0,
          (($urandom % 3) == 0) ? 6'($urandom % 56) : 6'h38 + 6'($urandom % 8),
          8'($urandom));
    end
    done = 1;
    report();
  end
endmodule